// File: doc/BRIEF.md
# Prioritised DMA Channel Arbiter with Cascade

This block decides which of a small set of DMA request lines owns the system bus. A channel whose request is high and whose mask bit is clear is eligible. Any eligible request makes the arbiter raise a hold request toward the bus owner. Once the hold acknowledge comes back, the arbiter asserts the acknowledge strobe of exactly one winning channel. Priority is fixed, and the lowest channel index wins. The grant is kept for as long as the winning channel holds its request high. When it drops, the arbiter gives the bus to the next eligible channel, or it releases the bus and drops the hold request.

A channel can be marked as a cascade channel. It is then granted with its acknowledge strobe only. The arbiter keeps its own address and strobe drive enable low, so an external bus master or a lower arbiter drives the bus. To build an eight-channel system, the hold request of a second instance is fed into a cascade channel of the first. The acknowledge of that channel is returned to the second instance as its hold acknowledge.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hold_req`, `chan_ack` and `bus_drive_en` are all low.
- R2: From the idle state, `hold_req` rises one clock after a request is sampled high on a channel whose `chan_mask` bit is 0. A request on a channel whose mask bit is 1 leaves `hold_req` low.
- R3: No `chan_ack` bit is asserted while `hold_ack` has not been sampled high. A grant appears one clock after `hold_ack` is sampled high with an eligible request pending.
- R4: When several eligible requests are pending at arbitration, the lowest channel index wins. Bit n of `chan_ack` belongs to channel n.
- R5: At most one `chan_ack` bit is high in any cycle.
- R6: While the granted channel keeps its request high and `hold_ack` stays high, the grant does not change. This holds even if a higher-priority channel starts requesting.
- R7: When the granted channel's request is sampled low, `chan_ack` goes low on the next clock. A new arbitration follows one clock later, so there is always one cycle without any acknowledge between two grants.
- R8: A channel whose `chan_cascade` bit is 1 when it is granted receives `chan_ack` with `bus_drive_en` low. A non-cascade grant has `bus_drive_en` high. `bus_drive_en` is never high without a grant.
- R9: If `hold_ack` is sampled low during a grant, `chan_ack` goes low on the next clock while `hold_req` stays high.
- R10: If no eligible request remains after a grant ends, the arbiter spends one cycle with `hold_req` high and `chan_ack` and `bus_drive_en` low. After that cycle it drops `hold_req`.
- R11: A second instance can be chained as follows. Its `hold_req` drives a cascade channel's request, and that channel's `chan_ack` drives its `hold_ack`. The second instance then grants its own channel one clock after the first instance's acknowledge, while the first instance keeps `bus_drive_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | NCH | Per-channel DMA request |
| chan_mask | input | NCH | Per-channel mask, 1 blocks the request from arbitration |
| chan_cascade | input | NCH | Per-channel cascade mode, 1 grants with acknowledge only |
| hold_ack | input | 1 | Bus hold acknowledge from the upstream owner |
| hold_req | output | 1 | Bus hold request to the upstream owner |
| chan_ack | output | NCH | One-hot per-channel acknowledge |
| bus_drive_en | output | 1 | Enables this arbiter's address and strobe drivers |

## Verification
All outputs come from registers. Every result is therefore due exactly one rising edge after the inputs that cause it are sampled: hold request after a request, grant after hold acknowledge, drop after a request or hold acknowledge falls, and release after the drain cycle. In the chained setup each stage adds one more edge. The slave grants two edges after the master first sees the slave's hold request. The driver changes inputs on the falling edge and queues the outputs expected after the next rising edge. The monitor checks them two nanoseconds after that rising edge, so each check lands on the one cycle where its result is due.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,  // bus not requested
    ARB_WAIT  = 2'd1,  // hold requested, no channel granted
    ARB_GRANT = 2'd2,  // one channel owns the bus
    ARB_DRAIN = 2'd3   // bus released, hold request still up
  } arb_state_e;

  // Index of the lowest set bit (highest priority); 0 when none set.
  function automatic int unsigned lowest_set(input logic [31:0] vec, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = int'(n) - 1; i >= 0; i--) begin
      if (vec[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/dma_arb_prio.sv
module dma_arb_prio #(
  parameter int NCH  = 4,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  eligible,
  output logic            any_eligible,
  output logic [IDXW-1:0] win_idx
);
  import dma_arb_pkg::*;

  logic [31:0] ext;

  always_comb begin
    ext = '0;
    ext[NCH-1:0] = eligible;
  end

  assign any_eligible = |eligible;
  assign win_idx      = IDXW'(lowest_set(ext, NCH));

endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm #(
  parameter int NCH  = 4,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  any_eligible,
  input  logic [IDXW-1:0]       win_idx,
  input  logic                  win_cascade,
  input  logic                  active_req,
  input  logic                  hold_ack,
  output dma_arb_pkg::arb_state_e state,
  output logic [IDXW-1:0]       owner_idx,
  output logic                  owner_cascade,
  output logic                  grant_go,
  output logic                  grant_end
);
  import dma_arb_pkg::*;

  arb_state_e state_d;

  always_comb begin
    state_d   = state;
    grant_go  = 1'b0;
    grant_end = 1'b0;
    unique case (state)
      ARB_IDLE:  if (any_eligible) state_d = ARB_WAIT;
      ARB_WAIT: begin
        if (!any_eligible) begin
          state_d = ARB_DRAIN;
        end else if (hold_ack) begin
          state_d  = ARB_GRANT;
          grant_go = 1'b1;
        end
      end
      ARB_GRANT: begin
        if (!hold_ack || !active_req) begin
          state_d   = ARB_WAIT;
          grant_end = 1'b1;
        end
      end
      ARB_DRAIN: state_d = ARB_IDLE;
      default:   state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ARB_IDLE;
      owner_idx     <= '0;
      owner_cascade <= 1'b0;
    end else begin
      state <= state_d;
      if (grant_go) begin
        owner_idx     <= win_idx;
        owner_cascade <= win_cascade;
      end
    end
  end

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NCH  = 4,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] chan_cascade,
  input  logic           hold_ack,
  output logic           hold_req,
  output logic [NCH-1:0] chan_ack,
  output logic           bus_drive_en
);
  import dma_arb_pkg::*;

  logic [NCH-1:0]  eligible;
  logic            any_eligible;
  logic [IDXW-1:0] win_idx;
  logic [IDXW-1:0] owner_idx;
  logic            owner_cascade;
  logic            grant_go;
  logic            grant_end;
  arb_state_e      state;

  assign eligible = chan_req & ~chan_mask;

  dma_arb_prio #(.NCH(NCH)) u_prio (
    .eligible     (eligible),
    .any_eligible (any_eligible),
    .win_idx      (win_idx)
  );

  dma_arb_fsm #(.NCH(NCH)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .any_eligible  (any_eligible),
    .win_idx       (win_idx),
    .win_cascade   (chan_cascade[win_idx]),
    .active_req    (chan_req[owner_idx]),
    .hold_ack      (hold_ack),
    .state         (state),
    .owner_idx     (owner_idx),
    .owner_cascade (owner_cascade),
    .grant_go      (grant_go),
    .grant_end     (grant_end)
  );

  assign hold_req = (state != ARB_IDLE);

  for (genvar g = 0; g < NCH; g++) begin : g_ack
    assign chan_ack[g] = (state == ARB_GRANT) && (owner_idx == IDXW'(g));
  end

  assign bus_drive_en = (state == ARB_GRANT) && !owner_cascade;

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_req,
  input logic [NCH-1:0] chan_mask,
  input logic [NCH-1:0] chan_cascade,
  input logic           hold_ack,
  input logic           hold_req,
  input logic [NCH-1:0] chan_ack,
  input logic           bus_drive_en
);

  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_ack));

  assert_req_raises_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_req && |(chan_req & ~chan_mask)) |=> hold_req);

  assert_ack_needs_hlda_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|chan_ack) |-> $past(hold_ack));

  assert_hold_while_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_ack && hold_ack && |(chan_req & chan_ack)) |=> $stable(chan_ack));

  assert_gap_after_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_ack && !(|(chan_req & chan_ack))) |=> !(|chan_ack));

  assert_cascade_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|chan_ack) |-> (bus_drive_en != |($past(chan_cascade) & chan_ack)));

  assert_drive_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> |chan_ack);

  assert_hlda_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_ack && !hold_ack) |=> (!(|chan_ack) && hold_req));

  assert_release_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |-> $past(!(|chan_ack) && !bus_drive_en));

endmodule

bind dma_chan_arbiter dma_arb_checker #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chan_req     (chan_req),
  .chan_mask    (chan_mask),
  .chan_cascade (chan_cascade),
  .hold_ack     (hold_ack),
  .hold_req     (hold_req),
  .chan_ack     (chan_ack),
  .bus_drive_en (bus_drive_en)
);

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] t_req = '0, t_mask = '0, t_casc = '0, s_req = '0;
  logic       t_hlda = 1'b0;
  logic       m_hrq, m_en, s_hrq, s_en;
  logic [3:0] m_ack, s_ack;
  logic [3:0] m_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // master channel 0 carries the slave's hold request
  assign m_req = t_req | {3'b000, s_hrq};

  dma_chan_arbiter #(.NCH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_req(m_req), .chan_mask(t_mask),
    .chan_cascade(t_casc), .hold_ack(t_hlda), .hold_req(m_hrq),
    .chan_ack(m_ack), .bus_drive_en(m_en)
  );

  dma_chan_arbiter #(.NCH(4)) u_slave (
    .clk(clk), .rst_n(rst_n), .chan_req(s_req), .chan_mask(4'b0000),
    .chan_cascade(4'b0000), .hold_ack(m_ack[0]), .hold_req(s_hrq),
    .chan_ack(s_ack), .bus_drive_en(s_en)
  );

  typedef struct {
    logic       hrq;
    logic [3:0] ack;
    logic       en;
    logic [3:0] sack;
    string      tag;
  } exp_t;

  exp_t sb[$];

  task automatic check_now(input exp_t e);
    checks++;
    if (m_hrq !== e.hrq || m_ack !== e.ack || m_en !== e.en || s_ack !== e.sack) begin
      errors++;
      $display("FAIL %s: hrq/ack/en/sack = %b/%b/%b/%b expected %b/%b/%b/%b",
               e.tag, m_hrq, m_ack, m_en, s_ack, e.hrq, e.ack, e.en, e.sack);
    end
  endtask

  // driver: apply inputs at falling edge, queue outputs due after next rising edge
  task automatic step(input logic [3:0] rq, input logic [3:0] mk, input logic [3:0] cs,
                      input logic hl, input logic [3:0] srq,
                      input logic e_hrq, input logic [3:0] e_ack, input logic e_en,
                      input logic [3:0] e_sack, input string tag);
    exp_t e;
    @(negedge clk);
    t_req = rq; t_mask = mk; t_casc = cs; t_hlda = hl; s_req = srq;
    e.hrq = e_hrq; e.ack = e_ack; e.en = e_en; e.sack = e_sack; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) check_now(sb.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    #1;
    r.hrq = 0; r.ack = 0; r.en = 0; r.sack = 0; r.tag = "R1 in reset";
    check_now(r);
    @(negedge clk); rst_n = 1'b1;
    step(4'b0000, 4'b0000, 4'b0000, 0, 4'b0000, 0, 4'b0000, 0, 4'b0000, "R1 after reset");
    step(4'b0100, 4'b0000, 4'b0000, 0, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R2 hold raised");
    step(4'b0100, 4'b0000, 4'b0000, 0, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R3 no ack without hlda");
    step(4'b0110, 4'b0000, 4'b0000, 1, 4'b0000, 1, 4'b0010, 1, 4'b0000, "R4 lowest index wins");
    step(4'b0111, 4'b0000, 4'b0000, 1, 4'b0000, 1, 4'b0010, 1, 4'b0000, "R6 no preemption");
    step(4'b0101, 4'b0000, 4'b0000, 1, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R7 gap after drop");
    step(4'b0101, 4'b0000, 4'b0000, 1, 4'b0000, 1, 4'b0001, 1, 4'b0000, "R7 next grant ch0");
    step(4'b0100, 4'b0000, 4'b0000, 1, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R7 gap again");
    step(4'b0100, 4'b0000, 4'b0100, 1, 4'b0000, 1, 4'b0100, 0, 4'b0000, "R8 cascade ack only");
    step(4'b0100, 4'b0000, 4'b0100, 0, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R9 hlda drop");
    step(4'b0000, 4'b0000, 4'b0000, 0, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R10 drain cycle");
    step(4'b0000, 4'b0000, 4'b0000, 0, 4'b0000, 0, 4'b0000, 0, 4'b0000, "R10 hold dropped");
    step(4'b1000, 4'b1000, 4'b0000, 0, 4'b0000, 0, 4'b0000, 0, 4'b0000, "R2 masked ignored");
    step(4'b1001, 4'b0001, 4'b0000, 0, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R2 unmasked raises");
    step(4'b1001, 4'b0001, 4'b0000, 1, 4'b0000, 1, 4'b1000, 1, 4'b0000, "R4 masked ch0 skipped");
    step(4'b0000, 4'b0000, 4'b0000, 1, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R7 drop ch3");
    step(4'b0000, 4'b0000, 4'b0000, 1, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R10 drain with hlda");
    step(4'b0000, 4'b0000, 4'b0000, 0, 4'b0000, 0, 4'b0000, 0, 4'b0000, "R10 idle");
    // chained slave on cascade channel 0
    step(4'b0000, 4'b0000, 4'b0001, 1, 4'b0010, 0, 4'b0000, 0, 4'b0000, "R11 slave hold pending");
    step(4'b0000, 4'b0000, 4'b0001, 1, 4'b0010, 1, 4'b0000, 0, 4'b0000, "R11 master hold");
    step(4'b0000, 4'b0000, 4'b0001, 1, 4'b0010, 1, 4'b0001, 0, 4'b0000, "R11 master cascade grant");
    step(4'b0000, 4'b0000, 4'b0001, 1, 4'b0010, 1, 4'b0001, 0, 4'b0010, "R11 slave grant");
    step(4'b0000, 4'b0000, 4'b0001, 1, 4'b0000, 1, 4'b0001, 0, 4'b0000, "R11 slave drop");
    step(4'b0000, 4'b0000, 4'b0001, 1, 4'b0000, 1, 4'b0001, 0, 4'b0000, "R11 slave drain");
    step(4'b0000, 4'b0000, 4'b0001, 1, 4'b0000, 1, 4'b0001, 0, 4'b0000, "R11 master holds");
    step(4'b0000, 4'b0000, 4'b0001, 1, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R11 master drop");
    step(4'b0000, 4'b0000, 4'b0001, 1, 4'b0000, 1, 4'b0000, 0, 4'b0000, "R10 master drain");
    step(4'b0000, 4'b0000, 4'b0001, 0, 4'b0000, 0, 4'b0000, 0, 4'b0000, "R10 master idle");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule